// File: doc/BRIEF.md
# Buffered SPI Master

This block is a master-only SPI engine. Software loads bytes into a one-byte holding buffer through a small register port. As soon as the shift stage is idle, a queued byte moves into it and is shifted out on MOSI over eight serial clock periods. In every frame, eight bits are taken in from MISO at the same time. When the receiver is enabled, the byte that arrives is kept in a receive buffer. Only the transmit side drives the serial clock, so every transfer is started by a byte written for transmission.

Three status flags track the traffic:

- receive done
- transmit done
- holding buffer empty

Each flag has its own interrupt enable. The single interrupt line is the OR of those flags whose enable is set, and the whole line is gated by a global enable input.

The frame format is programmable: bit order, sampling phase and the idle level of the clock. The serial clock rate comes from a divider register. Switching the transmitter off is delayed until every queued bit has gone out. Switching the receiver off discards the byte it holds. Two outputs report whether the transmit and receive sides currently own their data pins.

Top module: `spi_buf_master`

## Requirements
- R1: With the transmitter enable (CTRL bit 4) at 0, a write to DATA (address 0) is ignored. With the receiver enable (CTRL bit 3) set alone, no frame runs: SCLK stays at its idle level and no status flag other than buffer-empty (STAT bit 2) is set.
- R2: Each frame carries 8 bits. While SCLK is idle it equals the polarity bit (FMT bit 2). Between leading edges inside a frame there are 2×(DIV+1) system clocks, where DIV is the register at address 4.
- R3: Clearing CTRL bit 4 takes effect only after both the shift stage and the holding buffer are empty. Until then, the frame in progress and the queued frame both complete, and `mosi_own_o` stays 1. After that point `mosi_own_o` is 0.
- R4: Clearing CTRL bit 3 clears receive-done (STAT bit 0) and makes a read of DATA return 0. `miso_own_o` follows CTRL bit 3.
- R5: `irq_o` is 1 exactly when `gie_i` is 1 and at least one status flag is set together with its enable. The enables are in CTRL: bit 0 for receive-done, bit 1 for transmit-done, bit 2 for buffer-empty.
- R6: With FMT bit 0 at 1, bits are sent and received LSB first. With FMT bit 0 at 0, they are sent and received MSB first.
- R7: With FMT bit 1 at 0, MISO is sampled on the leading SCLK edge and MOSI changes on the trailing edge. With FMT bit 1 at 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R8: Unused bits read as 0: CTRL[7:5], FMT[7:3], STAT[7:3], and all of addresses 5 to 7.
- R9: STAT bit 2 is 1 whenever the holding buffer can take a byte. A byte written while a frame is running is sent immediately after that frame, with no transmit-done flag in between.
- R10: Transmit-done (STAT bit 1) is set when a frame ends with the holding buffer empty. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R11: When a frame ends with the receiver enabled, the received byte is kept and receive-done is set. A read of DATA clears receive-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Gated interrupt request |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| mosi_own_o | output | 1 | Transmitter owns the data-out pin |
| miso_own_o | output | 1 | Receiver owns the data-in pin |

## Verification
The hardest state to reach from the ports is a deferred transmitter shutdown with two bytes pending: one byte shifting and one held in the buffer at the moment the enable is cleared. The bench writes the first byte and polls the buffer-empty flag until that byte has moved into the shifter. It then writes the second byte and clears the enable at once. A slave model in the bench collects all sixteen MOSI bits and tracks pin ownership until the drain is finished. Phase handling is exercised by a sweep over all polarity, phase, order and divider combinations. In that sweep the slave model drives MISO on the opposite edge from the one it samples on.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int FRAME_W = 8;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA = 3'd0,
        A_STAT = 3'd1,
        A_CTRL = 3'd2,
        A_FMT  = 3'd3,
        A_DIV  = 3'd4
    } reg_addr_e;

    // CTRL layout, bit 4 down to bit 0
    typedef struct packed {
        logic tx_on;
        logic rx_on;
        logic ie_empty;
        logic ie_tx;
        logic ie_rx;
    } ctrl_t;

    // FMT layout, bit 2 down to bit 0
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } fmt_t;

    // STAT layout, bit 2 down to bit 0
    typedef struct packed {
        logic buf_empty;
        logic tx_done;
        logic rx_done;
    } stat_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int FMT_W  = $bits(fmt_t);
    localparam int STAT_W = $bits(stat_t);

    function automatic logic [FRAME_W-1:0] bit_rev(input logic [FRAME_W-1:0] v);
        logic [FRAME_W-1:0] r;
        for (int i = 0; i < FRAME_W; i++) r[i] = v[FRAME_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt == div)  cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    // R2: half-period spacing, two ticks never adjacent unless divider is zero
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0 && run) |=> !tick);

endmodule

// File: rtl/spim_frame.sv
module spim_frame
    import spim_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               cpha,
    input  logic               tick,
    input  logic               miso,
    output logic               busy,
    output logic               phase,
    output logic               mosi,
    output logic               done,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int EW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sh;
    logic [FRAME_W-1:0] rsh;
    logic [EW-1:0]      edges;

    assign done    = busy && tick && phase && (edges == EW'(FRAME_W-1));
    assign rx_word = cpha ? {rsh[FRAME_W-2:0], miso} : rsh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= 1'b0;
            edges <= '0;
            sh    <= '0;
            rsh   <= '0;
            mosi  <= 1'b0;
        end else if (load) begin
            busy  <= 1'b1;
            phase <= 1'b0;
            edges <= '0;
            rsh   <= '0;
            if (!cpha) begin
                mosi <= load_data[FRAME_W-1];
                sh   <= load_data << 1;
            end else begin
                sh   <= load_data;
            end
        end else if (busy && tick) begin
            phase <= ~phase;
            if (!phase) begin
                // leading edge
                if (!cpha) rsh <= {rsh[FRAME_W-2:0], miso};
                else begin
                    mosi <= sh[FRAME_W-1];
                    sh   <= sh << 1;
                end
            end else begin
                // trailing edge
                if (!cpha) begin
                    mosi <= sh[FRAME_W-1];
                    sh   <= sh << 1;
                end else begin
                    rsh <= {rsh[FRAME_W-2:0], miso};
                end
                edges <= edges + 1'b1;
                if (edges == EW'(FRAME_W-1)) begin
                    busy  <= 1'b0;
                    phase <= 1'b0;
                end
            end
        end
    end

    // R9: the queue never hands over a byte while a frame is running
    a_r9_load_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);
    // R2: a frame only begins from a load request
    a_r2_start_from_load: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(load));

endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
    import spim_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              gie_i,
    output logic              irq_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              mosi_own_o,
    output logic              miso_own_o
);
    ctrl_t              ctrl_q;
    fmt_t               fmt_q;
    logic [DIV_W-1:0]   div_q;
    logic [FRAME_W-1:0] txbuf_q;
    logic               buf_full;
    logic               tx_act;
    logic [FRAME_W-1:0] rxbuf_q;
    logic               rx_done;
    logic               tx_done;
    stat_t              stat;

    logic               tick, busy, phase, done, load;
    logic [FRAME_W-1:0] rx_word;

    logic wr_data, wr_ctrl, wr_stat, rd_data, accept, rx_kill;

    assign wr_data = wr_en && (addr == A_DATA);
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign rd_data = rd_en && (addr == A_DATA);
    assign accept  = wr_data && ctrl_q.tx_on && !buf_full;
    assign load    = tx_act && buf_full && !busy;
    assign rx_kill = !ctrl_q.rx_on || (wr_ctrl && !wdata[3]);

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .div (div_q),
        .tick(tick)
    );

    spim_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_data(fmt_q.lsb_first ? bit_rev(txbuf_q) : txbuf_q),
        .cpha     (fmt_q.cpha),
        .tick     (tick),
        .miso     (miso_i),
        .busy     (busy),
        .phase    (phase),
        .mosi     (mosi_o),
        .done     (done),
        .rx_word  (rx_word)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            fmt_q  <= '0;
            div_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (addr == A_FMT)  fmt_q  <= fmt_t'(wdata[FMT_W-1:0]);
            if (addr == A_DIV)  div_q  <= DIV_W'(wdata);
        end
    end

    // transmit queue and deferred shutdown
    always_ff @(posedge clk) begin
        if (rst) begin
            txbuf_q  <= '0;
            buf_full <= 1'b0;
            tx_act   <= 1'b0;
            tx_done  <= 1'b0;
        end else begin
            if (accept) begin
                txbuf_q  <= wdata;
                buf_full <= 1'b1;
            end else if (load) begin
                buf_full <= 1'b0;
            end
            tx_act <= ctrl_q.tx_on || (tx_act && (buf_full || busy));
            if (done && !buf_full)            tx_done <= 1'b1;
            else if (wr_stat && wdata[1])     tx_done <= 1'b0;
        end
    end

    // receive buffer
    always_ff @(posedge clk) begin
        if (rst || rx_kill) begin
            rxbuf_q <= '0;
            rx_done <= 1'b0;
        end else if (done) begin
            rxbuf_q <= fmt_q.lsb_first ? bit_rev(rx_word) : rx_word;
            rx_done <= 1'b1;
        end else if (rd_data) begin
            rx_done <= 1'b0;
        end
    end

    assign stat       = '{buf_empty: !buf_full, tx_done: tx_done, rx_done: rx_done};
    assign sclk_o     = fmt_q.cpol ^ phase;
    assign mosi_own_o = tx_act;
    assign miso_own_o = ctrl_q.rx_on;
    assign irq_o      = gie_i && ((ctrl_q.ie_rx && stat.rx_done) ||
                                  (ctrl_q.ie_tx && stat.tx_done) ||
                                  (ctrl_q.ie_empty && stat.buf_empty));

    always_comb begin
        rdata = '0;
        case (addr)
            A_DATA: rdata = rxbuf_q;
            A_STAT: rdata = REG_W'(stat);
            A_CTRL: rdata = REG_W'(ctrl_q);
            A_FMT:  rdata = REG_W'(fmt_q);
            A_DIV:  rdata = REG_W'(div_q);
            default: rdata = '0;
        endcase
    end

    // R1: the shifter runs only while the transmit side is active
    a_r1_clock_from_tx: assert property (@(posedge clk) disable iff (rst)
        busy |-> tx_act);
    // R2: SCLK rests at the polarity level between frames
    a_r2_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk_o == fmt_q.cpol));
    // R3: pin ownership held while anything is left to send
    a_r3_drain_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_act && (buf_full || busy)) |=> tx_act);
    // R4: a disabled receiver never reports data
    a_r4_flush: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.rx_on |-> !rx_done);
    // R11: reading the data register clears receive-done
    a_r11_read_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done && !wr_en) |=> !rx_done);

endmodule

// File: tb/test_spi_buf_master.sv
module test_spi_buf_master;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       gie_i = 1'b0;
    logic       irq_o, sclk_o, mosi_o, miso_i, mosi_own_o, miso_own_o;

    always #4 clk = ~clk;

    spi_buf_master i_spi_buf_master (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .gie_i(gie_i), .irq_o(irq_o),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .mosi_own_o(mosi_own_o), .miso_own_o(miso_own_o)
    );

    int tests = 0, fails = 0;
    int cyc = 0;

    // slave model state
    logic [16:0] q = '0;
    logic [15:0] cap = '0;
    int          ncap = 0, nlead = 0, last_lead = 0, pmeas = 0;
    logic        prev_sclk = 1'b0, cpol_b = 1'b0, cpha_b = 1'b0;

    assign miso_i = q[16];

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            tests++; fails++;
            $display("FAIL watchdog: act=%0d exp<%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (sclk_o != prev_sclk) begin
            if (prev_sclk == cpol_b) begin
                if (nlead == 1) pmeas = cyc - last_lead;
                last_lead = cyc;
                nlead++;
                if (!cpha_b) begin cap = {cap[14:0], mosi_o}; ncap++; end
                else q = q << 1;
            end else begin
                if (!cpha_b) q = q << 1;
                else begin cap = {cap[14:0], mosi_o}; ncap++; end
            end
        end
        prev_sclk = sclk_o;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(posedge clk); #2;
        rd_en = 1'b1; addr = a;
        #2 d = rdata;
        @(posedge clk); #2;
        rd_en = 1'b0;
    endtask

    task automatic arm(logic cp, logic ph, logic [7:0] b0, logic [7:0] b1);
        @(posedge clk); #2;
        cpol_b = cp; cpha_b = ph;
        prev_sclk = sclk_o;
        q = ph ? {1'b0, b0, b1} : {b0, b1, 1'b0};
        cap = '0; ncap = 0; nlead = 0; pmeas = 0;
    endtask

    task automatic wait_flag(int bitpos);
        logic [7:0] s;
        for (int k = 0; k < 2000; k++) begin
            rd(3'd1, s);
            if (s[bitpos]) return;
        end
    endtask

    function automatic logic [7:0] rev(logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // reset state
        rd(3'd1, d); check("R9 reset stat", d, 8'h04);
        rd(3'd2, d); check("R1 reset ctrl", d, 8'h00);
        check("R2 reset sclk idle", sclk_o, 1'b0);
        check("R3 reset mosi_own", mosi_own_o, 1'b0);

        // R8 reserved bits
        wr(3'd2, 8'hFF); rd(3'd2, d); check("R8 ctrl reserved", d, 8'h1F);
        wr(3'd3, 8'hFF); rd(3'd3, d); check("R8 fmt reserved", d, 8'h07);
        rd(3'd5, d); check("R8 addr5", d, 8'h00);
        rd(3'd7, d); check("R8 addr7", d, 8'h00);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        rd(3'd1, d); check("R8 stat reserved", d & 8'hF8, 8'h00);

        // R1: receiver alone, writes ignored while transmitter off
        wr(3'd3, 8'h04);
        arm(1'b1, 1'b0, 8'h55, 8'h00);
        wr(3'd2, 8'h08);
        wr(3'd0, 8'h81);
        begin
            int bad = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk); if (sclk_o !== 1'b1) bad++;
            end
            check("R1 sclk idle with rx only", bad, 0);
        end
        rd(3'd1, d); check("R1 only empty flag", d, 8'h04);
        check("R1 rx owns pin", miso_own_o, 1'b1);
        check("R1 tx not owning", mosi_own_o, 1'b0);
        wr(3'd2, 8'h18);
        repeat (60) @(posedge clk);
        rd(3'd1, d); check("R1 ignored write sent nothing", d, 8'h04);
        check("R1 no edges", ncap, 0);
        wr(3'd2, 8'h00);

        // R2 R6 R7 R11 sweep over format and divider
        for (int c = 0; c < 16; c++) begin
            logic cp, ph, lsb;
            logic [7:0] tx, sv, dv;
            cp = c[0]; ph = c[1]; lsb = c[2];
            dv = c[3] ? 8'd2 : 8'd0;
            tx = 8'h3C ^ 8'(c * 37);
            sv = 8'hA5 + 8'(c * 11);
            wr(3'd3, {5'b0, cp, ph, lsb});
            wr(3'd4, dv);
            wr(3'd2, 8'h18);
            arm(cp, ph, sv, 8'h00);
            wr(3'd0, tx);
            wait_flag(1);
            check($sformatf("R7 R6 mosi bits cfg%0d", c), cap[7:0], lsb ? rev(tx) : tx);
            check($sformatf("R2 frame bits cfg%0d", c), ncap, 8);
            check($sformatf("R2 period cfg%0d", c), pmeas, 2 * (dv + 1));
            rd(3'd1, d); check($sformatf("R11 rx flag cfg%0d", c), d[0], 1'b1);
            rd(3'd0, d); check($sformatf("R7 R6 miso byte cfg%0d", c), d, lsb ? rev(sv) : sv);
            rd(3'd1, d); check($sformatf("R11 read clears cfg%0d", c), d[0], 1'b0);
            check($sformatf("R2 sclk idle after cfg%0d", c), sclk_o, cp);
            wr(3'd1, 8'h02);
        end

        // R9 back-to-back
        wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd2, 8'h18);
        arm(1'b0, 1'b0, 8'h12, 8'hE7);
        wr(3'd0, 8'hC3);
        wait_flag(2);
        wr(3'd0, 8'h5A);
        rd(3'd1, d); check("R9 buffer full while shifting", d[2], 1'b0);
        wait_flag(1);
        check("R9 no done between frames", ncap, 16);
        check("R9 both bytes sent", cap, 16'hC35A);
        rd(3'd0, d); check("R11 last byte kept", d, 8'hE7);

        // R10 write-one-to-clear
        wr(3'd1, 8'h00); rd(3'd1, d); check("R10 write 0 keeps", d[1], 1'b1);
        wr(3'd1, 8'h02); rd(3'd1, d); check("R10 write 1 clears", d[1], 1'b0);

        // R3 deferred shutdown with two bytes pending
        wr(3'd4, 8'h01);
        arm(1'b0, 1'b0, 8'h00, 8'h9D);
        wr(3'd0, 8'hA1);
        wait_flag(2);
        wr(3'd0, 8'h7E);
        wr(3'd2, 8'h08);
        check("R3 still owns pin", mosi_own_o, 1'b1);
        wait_flag(1);
        check("R3 drained both", cap, 16'hA17E);
        repeat (3) @(posedge clk); #2;
        check("R3 released pin", mosi_own_o, 1'b0);
        wr(3'd0, 8'h33);
        repeat (40) @(posedge clk);
        rd(3'd1, d); check("R3 disabled ignores data", d[2], 1'b1);
        check("R3 no extra frame", ncap, 16);

        // R4 flush
        rd(3'd1, d); check("R4 rx flag before flush", d[0], 1'b1);
        wr(3'd2, 8'h00);
        rd(3'd1, d); check("R4 rx flag flushed", d[0], 1'b0);
        rd(3'd0, d); check("R4 buffer flushed", d, 8'h00);
        check("R4 pin released", miso_own_o, 1'b0);

        // R5 interrupt gating
        wr(3'd1, 8'h02);
        wr(3'd2, 8'h04); gie_i = 1'b0; #1;
        check("R5 global gate", irq_o, 1'b0);
        gie_i = 1'b1; #1;
        check("R5 empty irq", irq_o, 1'b1);
        wr(3'd2, 8'h02); #1;
        check("R5 tx irq without flag", irq_o, 1'b0);
        wr(3'd2, 8'h19); #1;
        check("R5 rx irq before frame", irq_o, 1'b0);
        arm(1'b0, 1'b0, 8'h44, 8'h00);
        wr(3'd0, 8'h0F);
        wait_flag(1);
        #1 check("R5 rx irq raised", irq_o, 1'b1);
        gie_i = 1'b0; #1;
        check("R5 gated off", irq_o, 1'b0);
        gie_i = 1'b1;
        rd(3'd0, d); #1;
        check("R11 R5 irq drops after read", irq_o, 1'b0);
        wr(3'd2, 8'h1A); #1;
        check("R5 tx irq with flag", irq_o, 1'b1);

        summary();
        $finish;
    end
endmodule